// File: doc/BRIEF.md
# Row-Aligned Page Write Collector

This block sits behind the serial-bus front end of a small non-volatile memory and gathers the data bytes of one write transaction. When the front end reports that a write has been addressed, the block latches the start address. The upper address bits fix the row, and the lower bits become a pointer into a 16-slot staging buffer. Each data byte that follows is answered with an accept or refuse decision. Accepted bytes are staged, and the in-row pointer advances after every byte. The pointer wraps within the row, so surplus bytes overwrite earlier slots.

A byte is refused when the write-inhibit input is high, or when the byte's address falls inside the protected upper region of the array. When the master ends the transaction with STOP, the block enters a timed program phase. During that phase it holds a busy flag for a fixed number of cycles and issues one array write strobe for each staged slot. A repeated START ends the transaction without writing anything.

Top module: `pgwr_buffer`

## Requirements
- R1: A `sel_i` pulse while idle opens a transaction. The row is taken from `start_addr_i[7:4]` and the slot pointer from `start_addr_i[3:0]`. An accepted byte is staged for array address {row, pointer}.
- R2: The pointer advances by one after every data byte, whether the byte was accepted or refused. It wraps from slot 15 to slot 0 within the same row, and a later byte aimed at a slot replaces the earlier one.
- R3: While `wc_i` is high, every data byte is refused (`ack_o`=0) and nothing is staged.
- R4: When `prot_en_i` is 1 and the byte's address is at or above `prot_lo_i`, the byte is refused and not staged. A byte with `wc_i` low at an unprotected address is accepted (`ack_o`=1).
- R5: `ack_vld_o` and `ack_o` appear in the cycle after the byte is presented on `byte_vld_i`. Bytes presented with no transaction open produce no response.
- R6: A `stop_i` pulse with at least one staged slot raises `busy_o` in the next cycle and holds it for PROG_CYCLES cycles. In busy cycle i (counting from 0), slot i is written with `mem_we_o` if it is staged. Slots are therefore written in ascending order, and no strobe occurs outside busy.
- R7: `sel_i` and data bytes are ignored while `busy_o` is high. They open no transaction and get no response.
- R8: A `rstart_i` pulse while a transaction is open discards all staged bytes. No busy phase and no writes follow, and a later `stop_i` has no effect.
- R9: A `stop_i` pulse with no staged slot returns the block to idle without raising busy or issuing writes.
- R10: After reset, `busy_o`, `mem_we_o` and `ack_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wc_i | input | 1 | Write inhibit; high refuses all data bytes |
| prot_en_i | input | 1 | Enables the protected region |
| prot_lo_i | input | 8 | Lowest protected address |
| sel_i | input | 1 | Pulse: write transaction addressed |
| start_addr_i | input | 8 | Start address, valid with `sel_i` |
| byte_vld_i | input | 1 | Pulse: data byte received, decision requested |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Pulse: STOP seen |
| rstart_i | input | 1 | Pulse: repeated START seen |
| ack_vld_o | output | 1 | Decision valid |
| ack_o | output | 1 | 1 = accept, 0 = refuse |
| busy_o | output | 1 | Program phase in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The accept/refuse decision is registered once, so the bench presents a byte at a falling edge and reads `ack_vld_o`/`ack_o` at the following falling edge. That is exactly one rising edge later. `busy_o` is set by the edge that samples `stop_i`, so the bench starts counting busy cycles at the first falling edge after the STOP pulse. The bench records each strobe together with the busy-cycle index where it appeared, then compares the slot, address, data and index against its own staging model. Cases with nothing to write are followed for several idle cycles to confirm that busy never rises.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      PG_IDLE    = 2'd0,
      PG_COLLECT = 2'd1,
      PG_COMMIT  = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgwr_prot.sv
module pgwr_prot #(
   parameter int ADDR_W   = 8,
   parameter bit HAS_PROT = 1'b1
) (
   input  logic              en_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   generate
      if (HAS_PROT) begin : g_cmp
         assign hit_o = en_i && (addr_i >= lo_i);
      end else begin : g_none
         logic unused_w;
         assign unused_w = en_i ^ (^lo_i) ^ (^addr_i);
         assign hit_o    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pgwr_slots.sv
module pgwr_slots #(
   parameter int DATA_W    = 8,
   parameter int ROW_BYTES = 16,
   localparam int OFS_W    = $clog2(ROW_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 wr_i,
   input  logic [OFS_W-1:0]     wr_idx_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic [OFS_W-1:0]     rd_idx_i,
   output logic                 rd_valid_o,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 any_valid_o
);
   logic [ROW_BYTES-1:0] valid_q;
   logic [DATA_W-1:0]    data_q [ROW_BYTES];

   generate
      for (genvar s = 0; s < ROW_BYTES; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[s] <= 1'b0;
               data_q[s]  <= '0;
            end else if (clear_i) begin
               valid_q[s] <= 1'b0;
            end else if (wr_i && (wr_idx_i == OFS_W'(s))) begin
               valid_q[s] <= 1'b1;
               data_q[s]  <= wr_data_i;
            end
         end
      end
   endgenerate

   assign rd_valid_o  = valid_q[rd_idx_i];
   assign rd_data_o   = data_q[rd_idx_i];
   assign any_valid_o = |valid_q;

   AST_STAGE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clear_i) |=> valid_q[$past(wr_idx_i)]) else $error("stage"); // R1
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !any_valid_o) else $error("clear"); // R8
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
   parameter int ROW_BYTES   = 16,
   parameter int PROG_CYCLES = 20,
   localparam int OFS_W      = $clog2(ROW_BYTES),
   localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             scan_act_o,
   output logic [OFS_W-1:0] scan_idx_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_o) begin
         if (done_o) busy_o <= 1'b0;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o     = busy_o && (cnt_q == CNT_W'(PROG_CYCLES - 1));
   assign scan_act_o = busy_o && (cnt_q < CNT_W'(ROW_BYTES));
   assign scan_idx_o = cnt_q[OFS_W-1:0];

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i)) else $error("busy start"); // R6
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int ROW_BYTES   = 16,
   parameter int PROG_CYCLES = 20,
   parameter bit HAS_PROT    = 1'b1,
   localparam int OFS_W      = $clog2(ROW_BYTES),
   localparam int ROW_W      = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wc_i,
   input  logic              prot_en_i,
   input  logic [ADDR_W-1:0] prot_lo_i,
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              rstart_i,
   output logic              ack_vld_o,
   output logic              ack_o,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   import pgwr_pkg::*;

   generate
      if (ROW_BYTES != (1 << OFS_W)) begin : g_chk_pow2
         $error("ROW_BYTES must be a power of two");
      end
      if (PROG_CYCLES < ROW_BYTES) begin : g_chk_prog
         $error("PROG_CYCLES must cover one scan of the row");
      end
      if (ADDR_W <= OFS_W) begin : g_chk_addr
         $error("ADDR_W must exceed row offset width");
      end
   endgenerate

   pg_state_e        st_q;
   logic [ROW_W-1:0] row_q;
   logic [OFS_W-1:0] ptr_q;
   logic             collecting, take_byte, accept, prot_hit;
   logic             open_txn, start_commit, drop_txn, idle_stop;
   logic             done, scan_act, slot_valid, any_valid;
   logic [OFS_W-1:0] scan_idx;
   logic [ADDR_W-1:0] byte_addr;

   assign collecting   = (st_q == PG_COLLECT);
   assign open_txn     = (st_q == PG_IDLE) && sel_i;
   assign take_byte    = collecting && byte_vld_i;
   assign byte_addr    = {row_q, ptr_q};
   assign accept       = !wc_i && !prot_hit;
   assign start_commit = collecting && stop_i && any_valid;
   assign idle_stop    = collecting && stop_i && !any_valid;
   assign drop_txn     = collecting && rstart_i && !stop_i;

   pgwr_prot #(.ADDR_W(ADDR_W), .HAS_PROT(HAS_PROT)) u_prot (
      .en_i   (prot_en_i),
      .lo_i   (prot_lo_i),
      .addr_i (byte_addr),
      .hit_o  (prot_hit)
   );

   pgwr_slots #(.DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (open_txn || drop_txn),
      .wr_i        (take_byte && accept),
      .wr_idx_i    (ptr_q),
      .wr_data_i   (byte_i),
      .rd_idx_i    (scan_idx),
      .rd_valid_o  (slot_valid),
      .rd_data_o   (mem_wdata_o),
      .any_valid_o (any_valid)
   );

   pgwr_commit #(.ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_commit),
      .busy_o     (busy_o),
      .done_o     (done),
      .scan_act_o (scan_act),
      .scan_idx_o (scan_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PG_IDLE;
         row_q <= '0;
         ptr_q <= '0;
      end else begin
         unique case (st_q)
            PG_IDLE: if (sel_i) begin
               st_q  <= PG_COLLECT;
               row_q <= start_addr_i[ADDR_W-1:OFS_W];
               ptr_q <= start_addr_i[OFS_W-1:0];
            end
            PG_COLLECT: begin
               if (start_commit)                st_q <= PG_COMMIT;
               else if (idle_stop || drop_txn)  st_q <= PG_IDLE;
               if (take_byte) ptr_q <= ptr_q + 1'b1;
            end
            PG_COMMIT: if (done) st_q <= PG_IDLE;
            default: st_q <= PG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vld_o <= 1'b0;
         ack_o     <= 1'b0;
      end else begin
         ack_vld_o <= take_byte;
         ack_o     <= take_byte && accept;
      end
   end

   assign mem_we_o   = scan_act && slot_valid;
   assign mem_addr_o = {row_q, scan_idx};

   AST_NACK_WHEN_WC: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && wc_i) |=> (ack_vld_o && !ack_o)) else $error("wc"); // R3
   AST_NACK_WHEN_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && prot_hit) |=> (ack_vld_o && !ack_o)) else $error("prot"); // R4
   AST_ACK_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld_o |-> $past(byte_vld_i)) else $error("ack timing"); // R5
   AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o) else $error("we outside busy"); // R6
   AST_SEL_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done && sel_i) |=> busy_o) else $error("sel busy"); // R7
   AST_RSTART_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      drop_txn |=> !busy_o) else $error("rstart"); // R8
   AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_stop |=> !busy_o) else $error("empty stop"); // R9
endmodule

// File: tb/pgwr_buffer_tb.sv
module pgwr_buffer_tb_top;
   localparam int PROG = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wc_i = 1'b0, prot_en_i = 1'b0, sel_i = 1'b0;
   logic       byte_vld_i = 1'b0, stop_i = 1'b0, rstart_i = 1'b0;
   logic [7:0] prot_lo_i = 8'hFF, start_addr_i = '0, byte_i = '0;
   logic       ack_vld_o, ack_o, busy_o, mem_we_o;
   logic [7:0] mem_addr_o, mem_wdata_o;

   int n_chk = 0, n_bad = 0;
   logic [3:0] m_row, m_ptr;
   logic [15:0] m_v;
   logic [7:0]  m_d [16];

   always #5 clk = ~clk;

   pgwr_buffer #(.PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .wc_i(wc_i), .prot_en_i(prot_en_i),
      .prot_lo_i(prot_lo_i), .sel_i(sel_i), .start_addr_i(start_addr_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
      .rstart_i(rstart_i), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
      .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic open_txn(input logic [7:0] a);
      @(negedge clk); sel_i = 1'b1; start_addr_i = a;
      @(negedge clk); sel_i = 1'b0;
      m_row = a[7:4]; m_ptr = a[3:0]; m_v = '0;
   endtask

   // byte in at one falling edge, decision read at the next
   task automatic send(input logic [7:0] d, input string req);
      logic [7:0] a;
      logic       exp_ack;
      a = {m_row, m_ptr};
      exp_ack = !wc_i && !(prot_en_i && (a >= prot_lo_i));
      @(negedge clk); byte_vld_i = 1'b1; byte_i = d;
      @(negedge clk); byte_vld_i = 1'b0;
      check({req, " ack_vld"}, int'(ack_vld_o), 1);
      check({req, " ack"}, int'(ack_o), int'(exp_ack));
      if (exp_ack) begin m_v[m_ptr] = 1'b1; m_d[m_ptr] = d; end
      m_ptr = m_ptr + 4'd1;
   endtask

   // STOP, then follow busy and compare each strobe with the model
   task automatic stop_and_check(input string req);
      int n, nw, k;
      logic [7:0] wa [16];
      logic [7:0] wd [16];
      int         wcyc [16];
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      n = 0; nw = 0;
      while (busy_o && n < 1000) begin
         if (mem_we_o && nw < 16) begin
            wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; wcyc[nw] = n; nw++;
         end
         n++;
         @(negedge clk);
      end
      k = 0;
      for (int s = 0; s < 16; s++) begin
         if (m_v[s]) begin
            if (k < nw) begin
               check({req, " addr"}, int'(wa[k]), int'({m_row, 4'(s)}));
               check({req, " data"}, int'(wd[k]), int'(m_d[s]));
               check({req, " slot cycle"}, wcyc[k], s);
            end
            k++;
         end
      end
      check({req, " write count"}, nw, k);
      check({req, " busy cycles"}, n, (k != 0) ? PROG : 0);
   endtask

   task automatic quiet_cycles(input int c, input string req);
      for (int i = 0; i < c; i++) begin
         @(negedge clk);
         check({req, " busy"}, int'(busy_o), 0);
         check({req, " we"}, int'(mem_we_o), 0);
      end
   endtask

   task automatic t_reset;
      check("R10 busy", int'(busy_o), 0);
      check("R10 we", int'(mem_we_o), 0);
      check("R10 ack_vld", int'(ack_vld_o), 0);
   endtask

   task automatic t_byte_write;
      open_txn(8'h35);
      send(8'hA5, "R1 R5");
      stop_and_check("R1 R6 single");
   endtask

   task automatic t_wrap;
      open_txn(8'h2E);
      for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), "R2 wrap");
      stop_and_check("R2 R6 wrap order");
      open_txn(8'h40);
      for (int i = 0; i < 18; i++) send(8'h80 + 8'(i), "R2 overflow");
      check("R2 slot0 overwritten", int'(m_d[0]), 8'h90);
      stop_and_check("R2 overflow commit");
   endtask

   task automatic t_wc;
      open_txn(8'h60);
      wc_i = 1'b1;
      send(8'h11, "R3 inhibited");
      send(8'h22, "R3 inhibited");
      wc_i = 1'b0;
      send(8'h33, "R3 released");
      stop_and_check("R3 commit");
   endtask

   task automatic t_prot;
      prot_en_i = 1'b1; prot_lo_i = 8'hC0;
      open_txn(8'hBE);
      send(8'h44, "R4 below");
      send(8'h55, "R4 below");
      stop_and_check("R4 below commit");
      open_txn(8'hC3);
      send(8'h66, "R4 protected");
      send(8'h77, "R4 protected");
      stop_and_check("R4 R9 nothing staged");
      quiet_cycles(3, "R9");
      prot_en_i = 1'b0;
      open_txn(8'hC3);
      send(8'h88, "R4 disabled");
      stop_and_check("R4 disabled commit");
   endtask

   task automatic t_rstart;
      open_txn(8'h70);
      send(8'h01, "R8 pre");
      send(8'h02, "R8 pre");
      @(negedge clk); rstart_i = 1'b1;
      @(negedge clk); rstart_i = 1'b0;
      check("R8 busy", int'(busy_o), 0);
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      quiet_cycles(PROG + 2, "R8 after stop");
   endtask

   task automatic t_busy_sel;
      open_txn(8'h90);
      send(8'h5A, "R7 setup");
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      check("R7 busy up", int'(busy_o), 1);
      sel_i = 1'b1; start_addr_i = 8'h12;
      @(negedge clk); sel_i = 1'b0;
      byte_vld_i = 1'b1; byte_i = 8'hEE;
      @(negedge clk); byte_vld_i = 1'b0;
      check("R7 no ack during busy", int'(ack_vld_o), 0);
      while (busy_o) @(negedge clk);
      @(negedge clk); byte_vld_i = 1'b1;
      @(negedge clk); byte_vld_i = 1'b0;
      check("R5 R7 no open txn", int'(ack_vld_o), 0);
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      quiet_cycles(3, "R7 no commit");
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_byte_write();
      t_wrap();
      t_wc();
      t_prot();
      t_rstart();
      t_busy_sel();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule